// File: doc/BRIEF.md
# Flash erase command sequence decoder

This block sits on the write side of a parallel flash bus. It watches an asynchronous active-low write strobe and brings it into the system clock domain through a synchroniser. On each rising edge of the strobe it captures the address and data buses. It matches the captured writes against a fixed six-write unlock-and-setup sequence. A complete sequence produces one single-cycle event for the erase engine: either a chip erase, or a sector erase together with the latched sector address.

While the erase engine reports busy, the decoder discards every write, with one exception. If the running operation is a sector erase, the suspend code raises a suspend pulse. Read cycles never touch the sequence state, because a read never produces a strobe edge. Any write that breaks the sequence returns the decoder to read-array (idle).

The decoder has no data stream that can stall, so it has no valid/ready interface. The event outputs are plain one-cycle pulses and cannot be back-pressured. The erase engine must take each pulse in the cycle it appears. The sector address output holds its value until the next sector erase event.

Top module: `flash_erase_cmd_decoder`

## Requirements
- R1: While reset is low, and in the first cycle after it, all three event outputs are 0 and the sector address output is 0.
- R2: One write is decoded for each rising edge of `wr_n`, taking the address and data present at that edge. Changes on the address and data buses while `wr_n` stays high, as during read cycles, do not advance or reset the sequence.
- R3: With the engine idle, the six writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 (address/data) produce exactly one `chip_erase_evt` pulse.
- R4: With the engine idle, the same first five writes followed by data 0x30 at any address produce exactly one `sector_erase_evt` pulse. In that cycle `sector_addr` equals the address of the sixth write.
- R5: A write that does not match the next expected step returns the decoder to idle. That write does not count as the first step of a new sequence.
- R6: While `engine_busy` is high after a chip erase launch, every write is ignored, including 0xB0, and no event is produced.
- R7: While `engine_busy` is high after a sector erase launch, a write of data 0xB0 at any address produces one `suspend_evt` pulse. All other writes are ignored, so even a complete six-write sequence produces no event.
- R8: Only address bits [10:0] are compared for the unlock, setup and chip erase steps. Higher address bits are don't-care.
- R9: Asserting reset in the middle of a sequence aborts it. The remaining writes after reset do not complete it.
- R10: At most one event output is high in any cycle. Data 0xB0 written while the engine is idle is a mismatch and produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, aborts any sequence |
| wr_n | input | 1 | Asynchronous active-low write strobe from the flash bus |
| bus_addr | input | ADDR_W | Flash bus address |
| bus_data | input | 8 | Flash bus data (command byte) |
| engine_busy | input | 1 | Erase engine running an operation |
| chip_erase_evt | output | 1 | One-cycle chip erase launch |
| sector_erase_evt | output | 1 | One-cycle sector erase launch |
| suspend_evt | output | 1 | One-cycle erase suspend request |
| sector_addr | output | ADDR_W | Address latched on the last sector erase launch |

## Verification
The embedded assertions check, on every cycle, the properties that hold cycle by cycle:
- the decoded write pulse lasts exactly one cycle;
- the event outputs are mutually exclusive;
- no launch is produced after a busy cycle;
- a suspend occurs only while a sector erase is running;
- a chip launch only follows the fifth sequence step;
- the idle state persists when no write arrives.

Only the bench scenarios can show the sequence-level behaviour:
- that a broken or mismatched sequence produces no event;
- that read-like bus activity is harmless;
- that the upper address bits are ignored;
- that a reset in mid-sequence aborts it;
- that the correct sector address accompanies each launch.

// File: rtl/fecd_pkg.sv
package fecd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KEY1  = 3'd1,
    ST_KEY2  = 3'd2,
    ST_ARMED = 3'd3,
    ST_KEY3  = 3'd4,
    ST_KEY4  = 3'd5
  } seq_state_t;

  localparam logic [10:0] ADDR_KEY_A = 11'h555;
  localparam logic [10:0] ADDR_KEY_B = 11'h2AA;
  localparam logic [7:0]  CODE_KEY_A = 8'hAA;
  localparam logic [7:0]  CODE_KEY_B = 8'h55;
  localparam logic [7:0]  CODE_SETUP = 8'h80;
  localparam logic [7:0]  CODE_CHIP  = 8'h10;
  localparam logic [7:0]  CODE_SECT  = 8'h30;
  localparam logic [7:0]  CODE_SUSP  = 8'hB0;
endpackage

// File: rtl/fecd_strobe_sync.sv
module fecd_strobe_sync #(
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wr_n};
      prev_q <= sync_q[LAST];
    end
  end

  assign rise = sync_q[LAST] & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_evt  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_evt <= rise;
      if (rise) begin
        wr_addr <= bus_addr;
        wr_data <= bus_data;
      end
    end
  end

  // R2: one strobe edge gives exactly one decoded write
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
endmodule

// File: rtl/fecd_seq_fsm.sv
module fecd_seq_fsm
  import fecd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MATCH_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              engine_busy,
  output logic              chip_evt,
  output logic              sector_evt,
  output logic              suspend_evt,
  output logic [ADDR_W-1:0] sector_addr
);
  seq_state_t state_q, state_d;
  logic       op_sector_q, op_sector_d;
  logic       chip_d, sect_d, susp_d;
  logic [MATCH_W-1:0] lo;
  logic key_a, key_b, is_setup, is_chip;

  assign lo       = wr_addr[MATCH_W-1:0];
  assign key_a    = (lo == ADDR_KEY_A[MATCH_W-1:0]) && (wr_data == CODE_KEY_A);
  assign key_b    = (lo == ADDR_KEY_B[MATCH_W-1:0]) && (wr_data == CODE_KEY_B);
  assign is_setup = (lo == ADDR_KEY_A[MATCH_W-1:0]) && (wr_data == CODE_SETUP);
  assign is_chip  = (lo == ADDR_KEY_A[MATCH_W-1:0]) && (wr_data == CODE_CHIP);

  always_comb begin
    state_d     = state_q;
    op_sector_d = op_sector_q;
    chip_d      = 1'b0;
    sect_d      = 1'b0;
    susp_d      = 1'b0;
    if (wr_evt) begin
      if (engine_busy) begin
        state_d = ST_IDLE;
        susp_d  = op_sector_q && (wr_data == CODE_SUSP);
      end else begin
        state_d = ST_IDLE;
        unique case (state_q)
          ST_IDLE:  if (key_a)    state_d = ST_KEY1;
          ST_KEY1:  if (key_b)    state_d = ST_KEY2;
          ST_KEY2:  if (is_setup) state_d = ST_ARMED;
          ST_ARMED: if (key_a)    state_d = ST_KEY3;
          ST_KEY3:  if (key_b)    state_d = ST_KEY4;
          ST_KEY4: begin
            if (is_chip) begin
              chip_d      = 1'b1;
              op_sector_d = 1'b0;
            end else if (wr_data == CODE_SECT) begin
              sect_d      = 1'b1;
              op_sector_d = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      op_sector_q <= 1'b0;
      chip_evt    <= 1'b0;
      sector_evt  <= 1'b0;
      suspend_evt <= 1'b0;
      sector_addr <= '0;
    end else begin
      state_q     <= state_d;
      op_sector_q <= op_sector_d;
      chip_evt    <= chip_d;
      sector_evt  <= sect_d;
      suspend_evt <= susp_d;
      if (sect_d) sector_addr <= wr_addr;
    end
  end

  // R10: events never overlap
  a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_evt, sector_evt, suspend_evt}));
  // R6/R7: no launch decoded from a busy cycle
  a_r6_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(engine_busy) |-> (!chip_evt && !sector_evt));
  // R7: suspend only during a busy sector erase
  a_r7_suspend_sector: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_evt |-> $past(engine_busy && op_sector_q));
  // R3: chip launch only after the fifth step
  a_r3_chip_after_key4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_evt |-> $past(state_q == ST_KEY4));
  // R2: without a write the idle state persists
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !wr_evt) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/flash_erase_cmd_decoder.sv
module flash_erase_cmd_decoder #(
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2,
  parameter int MATCH_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              engine_busy,
  output logic              chip_erase_evt,
  output logic              sector_erase_evt,
  output logic              suspend_evt,
  output logic [ADDR_W-1:0] sector_addr
);
  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  fecd_strobe_sync #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fecd_seq_fsm #(.ADDR_W(ADDR_W), .MATCH_W(MATCH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .engine_busy(engine_busy), .chip_evt(chip_erase_evt),
    .sector_evt(sector_erase_evt), .suspend_evt(suspend_evt),
    .sector_addr(sector_addr)
  );
endmodule

// File: tb/flash_erase_cmd_decoder_tb.sv
module flash_erase_cmd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;

  typedef struct {
    int                kind;
    logic [ADDR_W-1:0] addr;
    string             req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_data = '0;
  logic engine_busy = 1'b0;
  logic chip_erase_evt, sector_erase_evt, suspend_evt;
  logic [ADDR_W-1:0] sector_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t expq[$];

  flash_erase_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .bus_addr(bus_addr),
    .bus_data(bus_data), .engine_busy(engine_busy),
    .chip_erase_evt(chip_erase_evt), .sector_erase_evt(sector_erase_evt),
    .suspend_evt(suspend_evt), .sector_addr(sector_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  // monitor: pops expected items when the design produces an event
  always @(negedge clk) begin
    if (rst_n && (chip_erase_evt || sector_erase_evt || suspend_evt)) begin
      int kind;
      kind = chip_erase_evt ? 1 : (sector_erase_evt ? 2 : 3);
      check($countones({chip_erase_evt, sector_erase_evt, suspend_evt}) == 1,
            "R10", "overlapping events");
      if (expq.size() == 0) begin
        check(1'b0, "R5/R6/R7/R10", $sformatf("unexpected event actual=%0d expected=none", kind));
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(kind == e.kind, e.req,
              $sformatf("event kind actual=%0d expected=%0d", kind, e.kind));
        if (e.kind == 2)
          check(sector_addr == e.addr, e.req,
                $sformatf("sector_addr actual=%h expected=%h", sector_addr, e.addr));
      end
    end
  end

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic prefix(input logic [ADDR_W-1:0] hi);
    bus_write(hi | 20'h555, 8'hAA);
    bus_write(hi | 20'h2AA, 8'h55);
    bus_write(hi | 20'h555, 8'h80);
    bus_write(hi | 20'h555, 8'hAA);
    bus_write(hi | 20'h2AA, 8'h55);
  endtask

  task automatic push(input int k, input logic [ADDR_W-1:0] a, input string r);
    exp_t e;
    e.kind = k; e.addr = a; e.req = r;
    expq.push_back(e);
  endtask

  task automatic drain(input string req);
    repeat (12) @(negedge clk);
    check(expq.size() == 0, req,
          $sformatf("pending expected events actual=%0d expected=0", expq.size()));
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!chip_erase_evt && !sector_erase_evt && !suspend_evt && sector_addr == '0,
          "R1", "outputs during reset not zero");
    rst_n = 1'b1;
    @(negedge clk);
    check(!chip_erase_evt && !sector_erase_evt && !suspend_evt && sector_addr == '0,
          "R1", "outputs after reset not zero");

    // R3 chip erase
    prefix('0); push(1, '0, "R3"); bus_write(20'h555, 8'h10); drain("R3");

    // R4 sector erase, two different sectors
    prefix('0); push(2, 20'h4A000, "R4"); bus_write(20'h4A000, 8'h30); drain("R4");
    prefix('0); push(2, 20'hF8123, "R4"); bus_write(20'hF8123, 8'h30); drain("R4");

    // R2 read-like bus activity with strobe high between steps
    prefix('0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bus_addr = 20'h1234 * i; bus_data = 8'(i * 37);
    end
    push(1, '0, "R2"); bus_write(20'h555, 8'h10); drain("R2");

    // R5 mismatch in the middle, then wrong final code
    bus_write(20'h555, 8'hAA); bus_write(20'h2AA, 8'h55);
    bus_write(20'h555, 8'h81);
    bus_write(20'h555, 8'hAA); bus_write(20'h2AA, 8'h55);
    bus_write(20'h555, 8'h80); bus_write(20'h555, 8'hAA);
    drain("R5");
    prefix('0); bus_write(20'h555, 8'h20); drain("R5");
    // R5 a mismatching unlock-start write is not reused as step one
    bus_write(20'h555, 8'hAA); bus_write(20'h555, 8'hAA);
    bus_write(20'h2AA, 8'h55); bus_write(20'h555, 8'h80);
    bus_write(20'h555, 8'hAA); bus_write(20'h2AA, 8'h55);
    bus_write(20'h555, 8'h10); drain("R5");
    // chip code at wrong address is a mismatch (R8 compares low bits)
    prefix('0); bus_write(20'h554, 8'h10); drain("R8");

    // R8 upper address bits ignored
    prefix(20'hA8800); push(1, '0, "R8"); bus_write(20'h7F555, 8'h10); drain("R8");

    // R10 suspend code when engine idle
    bus_write(20'h0, 8'hB0); drain("R10");

    // R6 chip erase running
    prefix('0); push(1, '0, "R6"); bus_write(20'h555, 8'h10); drain("R6");
    engine_busy = 1'b1;
    bus_write(20'h0, 8'hB0);
    prefix('0); bus_write(20'h555, 8'h10);
    drain("R6");
    engine_busy = 1'b0;

    // R7 sector erase running
    prefix('0); push(2, 20'h30000, "R7"); bus_write(20'h30000, 8'h30); drain("R7");
    engine_busy = 1'b1;
    prefix('0); bus_write(20'h40000, 8'h30);
    drain("R7");
    check(sector_addr == 20'h30000, "R7",
          $sformatf("sector_addr changed actual=%h expected=30000", sector_addr));
    push(3, '0, "R7"); bus_write(20'h9ABCD, 8'hB0); drain("R7");
    engine_busy = 1'b0;

    // R9 reset mid-sequence
    bus_write(20'h555, 8'hAA); bus_write(20'h2AA, 8'h55); bus_write(20'h555, 8'h80);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(sector_addr == '0, "R9", $sformatf("sector_addr actual=%h expected=0", sector_addr));
    rst_n = 1'b1;
    bus_write(20'h555, 8'hAA); bus_write(20'h2AA, 8'h55); bus_write(20'h555, 8'h10);
    drain("R9");
    prefix('0); push(1, '0, "R9"); bus_write(20'h555, 8'h10); drain("R9");

    finish_run();
  end
endmodule